// File: doc/BRIEF.md
# Vector predicate pattern generator

This block serves the predicate-generation step of a scalable-vector unit. It accepts a 32-bit instruction word with a valid strobe and the current vector length, given as a count of 128-bit granules. It decodes three instruction forms: predicate initialise (optionally setting condition flags), predicate zero, and first-fault register initialise. From the decoded fields it builds a complete predicate value, with one bit for each byte of the longest supported vector. One cycle after the strobe it presents that value as a write request to an external predicate register file. The file has sixteen entries plus a first-fault register at index 16.

The number of active elements comes from a 5-bit pattern code applied to the element count. The element count is the vector length in bytes divided by the element size. Each active element sets only the lowest predicate bit of its byte group. All remaining bits up to the full predicate width are zero. A word that matches none of the three forms raises a one-cycle illegal indication and causes no write.

The vector length input is assumed to lie between 1 and the configured maximum number of granules.

Top module: `pred_pattern_gen`

## Requirements
- R1: The element count is (vl_gran*16) >> esz, where esz 0, 1, 2 and 3 mean 1-, 2-, 4- and 8-byte elements; pattern 31 makes every element active.
- R2: Pattern 0 makes active the largest power of two not above the element count.
- R3: Patterns 1 to 8 request that many elements, and patterns 9 to 13 request 16, 32, 64, 128 and 256 elements; the active count is the request capped at the element count.
- R4: Pattern 29 rounds the element count down to a multiple of 4, and pattern 30 rounds it down to a multiple of 3; patterns 14 to 28 give zero active elements.
- R5: Predicate bit i is 1 exactly when i is a multiple of 2^esz and i < (active count << esz); every bit above the vector length is 0.
- R6: When the initialise control is clear or the active count is zero, the written predicate is all zero.
- R7: With S=1 in the initialise form, flags_we pulses with the write, and flags = {N,Z,C,V} (bit 3 down to bit 0) with N=C=1 and Z=0 if any predicate bit is set, Z=1 and N=C=0 otherwise, and V=0 always; no other form pulses flags_we.
- R8: The initialise form has insn[31:24]=8'h25, esz in insn[23:22], insn[21:17]=5'b01100, S in insn[16], insn[15:10]=6'b111000, pattern in insn[9:5], insn[4]=0 and destination in insn[3:0].
- R9: The zero form, 32'h2518E400 with the destination in insn[3:0], writes an all-zero predicate to that destination.
- R10: The word 32'h252C9000 writes all-true byte elements for the full vector length to index 16 (the first-fault register).
- R11: Any other word pulses illegal for one cycle and causes no write.
- R12: wr_en, illegal and flags_we are one-cycle pulses in the cycle after a clock edge that sampled insn_valid=1. They are 0 at all other times, including during and after synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vl_gran | input | 5 | Vector length in 128-bit granules (1..16) |
| insn_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| wr_en | output | 1 | Predicate write request |
| wr_idx | output | 5 | Destination index, 16 = first-fault register |
| wr_data | output | 256 | Predicate value, one bit per vector byte |
| flags_we | output | 1 | Condition flag write request |
| flags | output | 4 | {N,Z,C,V} |
| illegal | output | 1 | Unrecognised instruction word |

## Verification
The bench builds the block with its default parameters: 16 granules of 16 bytes, giving a 2048-bit vector and a 256-bit predicate. This brings the largest fixed pattern (256 elements) within reach at byte size, together with capping at every shorter length. Random vector lengths from 1 to 16 exercise the multiple-of-3 and multiple-of-4 truncation over element counts from 2 to 256. They also exercise the power-of-two floor for counts that are not powers of two, such as 48 and 80 bytes.

// File: rtl/pgen_pkg.sv
// Shared encodings for the predicate pattern generator.
// Assumes the fixed 32-bit instruction layout of the three supported forms.
package pgen_pkg;
    localparam logic [31:0] INIT_MASK  = 32'hFF3E_FC10;
    localparam logic [31:0] INIT_MATCH = 32'h2518_E000;
    localparam logic [31:0] ZERO_MASK  = 32'hFFFF_FFF0;
    localparam logic [31:0] ZERO_MATCH = 32'h2518_E400;
    localparam logic [31:0] FFR_WORD   = 32'h252C_9000;
    localparam logic [4:0]  PAT_POW2   = 5'd0;
    localparam logic [4:0]  PAT_MUL4   = 5'd29;
    localparam logic [4:0]  PAT_MUL3   = 5'd30;
    localparam logic [4:0]  PAT_ALL    = 5'd31;
    localparam logic [4:0]  FFR_INDEX  = 5'd16;

    typedef struct packed {
        logic       legal;
        logic [4:0] rd;
        logic [1:0] esz;
        logic [4:0] pat;
        logic       init;
        logic       setf;
    } pgen_op_t;
endpackage

// File: rtl/pgen_decode.sv
// Instruction decoder: maps a 32-bit word onto the generator controls.
// Assumes the three forms do not overlap; anything else leaves legal=0.
module pgen_decode
    import pgen_pkg::*;
(
    input  logic [31:0] insn,
    output pgen_op_t    op
);
    // Match the word against each form and fill in implied fields.
    always_comb begin
        op = '0;
        if ((insn & INIT_MASK) == INIT_MATCH) begin
            op.legal = 1'b1;
            op.esz   = insn[23:22];
            op.setf  = insn[16];
            op.pat   = insn[9:5];
            op.rd    = {1'b0, insn[3:0]};
            op.init  = 1'b1;
        end else if ((insn & ZERO_MASK) == ZERO_MATCH) begin
            op.legal = 1'b1;
            op.pat   = PAT_ALL;
            op.rd    = {1'b0, insn[3:0]};
            op.init  = 1'b0;
        end else if (insn == FFR_WORD) begin
            op.legal = 1'b1;
            op.pat   = PAT_ALL;
            op.rd    = FFR_INDEX;
            op.init  = 1'b1;
        end
    end
endmodule

// File: rtl/pgen_count.sv
// Active element counter: turns vector length, element size and pattern
// into the number of active elements. Assumes vl_gran is within range.
module pgen_count
    import pgen_pkg::*;
#(
    parameter int GRAN_BYTES = 16,
    parameter int GW         = 5,
    parameter int CNT_W      = 9
) (
    input  logic [GW-1:0]    vl_gran,
    input  logic [1:0]       esz,
    input  logic [4:0]       pat,
    output logic [CNT_W-1:0] cnt
);
    int elems;
    int floor2;
    int want;
    int res;

    // Element count from length and size.
    always_comb elems = (int'(vl_gran) * GRAN_BYTES) >> esz;

    // Largest power of two not above the element count.
    always_comb begin
        floor2 = 0;
        for (int i = 0; i <= CNT_W; i++) begin
            if (((elems >> i) & 1) != 0) floor2 = 1 << i;
        end
    end

    // Requested count for the fixed-number patterns.
    always_comb begin
        if (pat <= 5'd8) want = int'(pat);
        else             want = 16 << (int'(pat) - 9);
    end

    // Select the active count by pattern code.
    always_comb begin
        if (pat == PAT_POW2)                       res = floor2;
        else if (pat <= 5'd13)                     res = (want < elems) ? want : elems;
        else if (pat == PAT_MUL4)                  res = elems - (elems % 4);
        else if (pat == PAT_MUL3)                  res = elems - (elems % 3);
        else if (pat == PAT_ALL)                   res = elems;
        else                                       res = 0;
    end

    assign cnt = CNT_W'(res);
endmodule

// File: rtl/pgen_mask.sv
// Predicate builder: sets the lowest bit of each active element.
// Assumes cnt never exceeds the element count of the current length.
module pgen_mask #(
    parameter int PRED_W = 256,
    parameter int CNT_W  = 9
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [1:0]        esz,
    input  logic              init,
    output logic [PRED_W-1:0] pred
);
    localparam int SPAN_W = CNT_W + 3;

    logic [SPAN_W-1:0] span;
    logic [2:0]        lowm;

    // Number of predicate bits covered by active elements.
    assign span = SPAN_W'(cnt) << esz;
    // Low-order bits that must be zero for an element's first byte.
    assign lowm = 3'((4'd1 << esz) - 4'd1);

    for (genvar b = 0; b < PRED_W; b++) begin : g_bit
        localparam logic [2:0] LOW = 3'(b % 8);
        // One predicate bit: inside the span and on an element boundary.
        assign pred[b] = init && (SPAN_W'(b) < span) && ((LOW & lowm) == 3'd0);
    end
endmodule

// File: rtl/pred_pattern_gen.sv
// Predicate pattern generator top: decodes the instruction, builds the
// predicate and flags, and registers a write request one cycle later.
// Assumes 1 <= vl_gran <= MAX_GRAN; the register file lives outside.
module pred_pattern_gen
    import pgen_pkg::*;
#(
    parameter  int MAX_GRAN   = 16,
    parameter  int GRAN_BYTES = 16,
    localparam int PRED_W     = MAX_GRAN * GRAN_BYTES,
    localparam int GW         = $clog2(MAX_GRAN + 1),
    localparam int CNT_W      = $clog2(PRED_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GW-1:0]     vl_gran,
    input  logic              insn_valid,
    input  logic [31:0]       insn,
    output logic              wr_en,
    output logic [4:0]        wr_idx,
    output logic [PRED_W-1:0] wr_data,
    output logic              flags_we,
    output logic [3:0]        flags,
    output logic              illegal
);
    pgen_op_t           op;
    logic [CNT_W-1:0]   cnt;
    logic [PRED_W-1:0]  pred;
    logic               any_set;

    pgen_decode u_decode (
        .insn (insn),
        .op   (op)
    );

    pgen_count #(
        .GRAN_BYTES (GRAN_BYTES),
        .GW         (GW),
        .CNT_W      (CNT_W)
    ) u_count (
        .vl_gran (vl_gran),
        .esz     (op.esz),
        .pat     (op.pat),
        .cnt     (cnt)
    );

    pgen_mask #(
        .PRED_W (PRED_W),
        .CNT_W  (CNT_W)
    ) u_mask (
        .cnt  (cnt),
        .esz  (op.esz),
        .init (op.init),
        .pred (pred)
    );

    // Any active bit drives N, C and the inverse of Z.
    assign any_set = |pred;

    // Strobe outputs: one-cycle pulses after a valid instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            illegal  <= 1'b0;
            flags_we <= 1'b0;
        end else begin
            wr_en    <= insn_valid && op.legal;
            illegal  <= insn_valid && !op.legal;
            flags_we <= insn_valid && op.legal && op.setf;
        end
    end

    // Payload registers: captured only on a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx  <= '0;
            wr_data <= '0;
            flags   <= '0;
        end else if (insn_valid) begin
            wr_idx  <= op.rd;
            wr_data <= pred;
            flags   <= {any_set, !any_set, any_set, 1'b0};
        end
    end

    // R11
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en && !flags_we);

    // R12
    idle_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(insn_valid) |-> !wr_en && !illegal && !flags_we);

    // R5
    beyond_vl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data >> (int'($past(vl_gran)) * GRAN_BYTES)) == '0);

    // R7
    flags_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags[2] == (wr_data == '0)) && (flags[3] == !flags[2])
                     && (flags[1] == !flags[2]) && !flags[0]);

    // R10
    ffr_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == FFR_INDEX) |-> $past(insn) == FFR_WORD);
endmodule

// File: tb/test_pred_pattern_gen.sv
module test_pred_pattern_gen;
    localparam int PW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    vl_gran = 5'd1;
    logic          insn_valid = 1'b0;
    logic [31:0]   insn = '0;
    logic          wr_en;
    logic [4:0]    wr_idx;
    logic [PW-1:0] wr_data;
    logic          flags_we;
    logic [3:0]    flags;
    logic          illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pred_pattern_gen i_pred_pattern_gen (
        .clk(clk), .rst_n(rst_n), .vl_gran(vl_gran), .insn_valid(insn_valid),
        .insn(insn), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .flags_we(flags_we), .flags(flags), .illegal(illegal)
    );

    task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_cnt(int vlg, int esz, int pat);
        int e = (vlg * 16) >> esz;
        int w;
        int p = 1;
        if (pat == 0) begin
            while (p * 2 <= e) p = p * 2;
            return p;
        end
        if (pat >= 1 && pat <= 8) begin w = pat; return (w < e) ? w : e; end
        if (pat >= 9 && pat <= 13) begin w = 16 << (pat - 9); return (w < e) ? w : e; end
        if (pat == 29) return (e / 4) * 4;
        if (pat == 30) return (e / 3) * 3;
        if (pat == 31) return e;
        return 0;
    endfunction

    function automatic logic [PW-1:0] exp_pred(int vlg, int esz, int pat, bit init);
        logic [PW-1:0] v = '0;
        int n = exp_cnt(vlg, esz, pat);
        for (int i = 0; i < PW; i++)
            if (init && i < (n << esz) && (i % (1 << esz)) == 0) v[i] = 1'b1;
        return v;
    endfunction

    // Issue one word and compare against the bench model; tag names the requirement.
    task automatic issue(int vlg, logic [31:0] w, string tag);
        bit is_init = (w & 32'hFF3EFC10) == 32'h2518E000;
        bit is_zero = (w & 32'hFFFFFFF0) == 32'h2518E400;
        bit is_ffr  = w == 32'h252C9000;
        bit legal   = is_init || is_zero || is_ffr;
        bit s       = is_init && w[16];
        int esz     = is_init ? int'(w[23:22]) : 0;
        int pat     = is_init ? int'(w[9:5]) : 31;
        int idx     = is_ffr ? 16 : int'(w[3:0]);
        logic [PW-1:0] ep = exp_pred(vlg, esz, pat, !is_zero);
        @(negedge clk);
        vl_gran = 5'(vlg); insn = w; insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
        chk({tag, " R11 illegal"}, PW'(illegal), PW'(!legal));
        chk({tag, " R8 wr_en"}, PW'(wr_en), PW'(legal));
        chk({tag, " R7 flags_we"}, PW'(flags_we), PW'(s));
        if (legal) begin
            chk({tag, " R8 wr_idx"}, PW'(wr_idx), PW'(idx));
            chk({tag, " R5 wr_data"}, wr_data, ep);
        end
        if (s) chk({tag, " R7 flags"}, PW'(flags),
                   PW'((ep != '0) ? 4'b1010 : 4'b0100));
    endtask

    function automatic logic [31:0] init_word(int esz, bit s, int pat, int rd);
        return 32'h2518E000 | (32'(esz) << 22) | (32'(s) << 16) | (32'(pat) << 5) | 32'(rd);
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset wr_en", PW'(wr_en), '0);
        chk("R12 reset illegal", PW'(illegal), '0);
        chk("R12 reset flags_we", PW'(flags_we), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after reset", PW'({wr_en, illegal, flags_we}), '0);

        issue(16, init_word(0, 0, 31, 3), "R1 all 256");
        chk("R1 full vector true", wr_data, {PW{1'b1}});
        issue(3, init_word(2, 1, 31, 1), "R1 words vl3");
        issue(3, init_word(0, 0, 0, 2), "R2 pow2 48");
        chk("R2 pow2 of 48 is 32", wr_data, PW'({32{1'b1}}));
        issue(1, init_word(3, 0, 5, 4), "R3 cap 2");
        issue(16, init_word(0, 1, 13, 5), "R3 vl256");
        issue(1, init_word(0, 0, 9, 6), "R3 vl16");
        issue(3, init_word(3, 0, 29, 7), "R4 mul4");
        issue(5, init_word(2, 1, 30, 8), "R4 mul3");
        chk("R4 mul3 18 words", wr_data, exp_pred(5, 2, 31, 1) & PW'({72{1'b1}}));
        issue(4, init_word(1, 1, 20, 9), "R4 R6 unused pat");
        chk("R7 zero count Z flag", PW'(flags), PW'(4'b0100));
        issue(16, 32'h2518E40B, "R9 R6 zero form");
        chk("R9 zero data", wr_data, '0);
        issue(7, 32'h252C9000, "R10 ffr");
        chk("R10 ffr idx", PW'(wr_idx), PW'(16));
        issue(2, 32'h00000000, "R11 zero word");
        issue(2, init_word(0, 0, 31, 0) | 32'h10, "R11 bit4 set");
        @(negedge clk);
        chk("R12 pulse ends", PW'({wr_en, illegal, flags_we}), '0);

        for (int k = 0; k < 400; k++) begin
            int vlg = 1 + int'($urandom % 16);
            int sel = int'($urandom % 8);
            logic [31:0] w;
            if (sel < 5)       w = init_word(int'($urandom % 4), bit'($urandom % 2),
                                             int'($urandom % 32), int'($urandom % 16));
            else if (sel == 5) w = 32'h2518E400 | 32'($urandom % 16);
            else if (sel == 6) w = 32'h252C9000;
            else               w = $urandom;
            issue(vlg, w, "R1 R5 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule